// File: doc/BRIEF.md
# Owner and Event Notification Register Slice

This block is a small register slice inside a streaming audio device that sits on a serial bus. It keeps three registers:

- a 64-bit owner address, made of a 16-bit node ID and a 48-bit offset;
- an event word that tells the owner what just happened;
- a clock-source status word that combines live lock flags with sticky slip flags.

Other parts of the device send single-cycle event pulses into the slice. These pulses report receive or transmit configuration changes, a change in lock of the current clock source, and completion of a clock selection. A change in any of the live per-source lock flags counts as an event too. Every cycle with at least one event replaces the whole event word with the new set. If an owner is registered, the slice also issues a notification write request aimed at the owner's address, carrying the new event word.

A host reaches the slice through a one-request-per-cycle port that supports quadlet read, quadlet write and 64-bit compare-swap. The response arrives on the following cycle. The owner register changes only through a compare-swap, or through a bus reset, which frees it.

Top module: `owner_notify_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the owner reads as 0xFFFF_0000_0000_0000 (no owner). The event word and the slip flags are zero. No response and no notification is issued.
- R2: A bus_reset pulse returns the owner to the no-owner value on the next cycle. This takes priority over a compare-swap in the same cycle.
- R3: A compare-swap (op 2) at offset 0x00 returns the old 64-bit owner with ok=1. It stores the swap operand only when the old owner equals the compare operand. Nothing else changes the owner.
- R4: The event word (read at offset 0x08) uses these bits: bit0 receive config changed, bit1 transmit config changed, bit4 current-source lock changed, bit5 clock select accepted, bit6 clock-source status changed. Events in the same cycle are ORed together. Any cycle with at least one event replaces all earlier bits with the new set.
- R5: One cycle after an event cycle, ntf_valid is high for one cycle. ntf_node and ntf_offset hold the owner's bits 63:48 and 47:0 as they were in the event cycle, and ntf_data holds the new event word. No request is issued while the owner is the no-owner value.
- R6: Bits 10:0 of the status word (offset 0x0C) show src_lock as it is in the request cycle. A change of src_lock from one cycle to the next is an event that sets bit6.
- R7: A src_slip pulse sets the matching bit 16+i of the status word, and that bit stays set until a quadlet read of offset 0x0C. That read returns the flags as they were and clears them; a slip in the same cycle as the read survives. Slips raise no event.
- R8: Every request gets a response exactly one cycle later. Quadlet reads (op 0) at 0x00/0x04/0x08/0x0C return the owner's high word, the owner's low word, the event word and the status word, zero-extended, with ok=1. Writes (op 1), misaligned or unmapped reads, compare-swaps at any other offset, and op 3 return ok=0 with data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse; frees the owner |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr | input | AW | Byte offset |
| req_cmp | input | 64 | Compare operand for compare-swap |
| req_wdata | input | 64 | Swap operand (or write data) |
| rsp_valid | output | 1 | Response valid |
| rsp_ok | output | 1 | Request accepted |
| rsp_rdata | output | 64 | Read data or old owner |
| evt_rx_cfg | input | 1 | Receive configuration changed |
| evt_tx_cfg | input | 1 | Transmit configuration changed |
| evt_lock | input | 1 | Current-source lock changed |
| evt_clk_acc | input | 1 | Clock selection accepted |
| src_lock | input | NSRC | Live lock flag for each clock source |
| src_slip | input | NSRC | Slip error pulse for each clock source |
| ntf_valid | output | 1 | Notification write request |
| ntf_node | output | 16 | Destination node ID |
| ntf_offset | output | 48 | Destination offset |
| ntf_data | output | 32 | Notification value |

## Verification
The hardest cases to reach from the ports are collisions within a single cycle. One is a bus reset that lands in the same cycle as a matching compare-swap. Another is a slip pulse that arrives in the same cycle as the read that clears the slip flags. A third is an event that fires in the same cycle as a compare-swap that changes the owner, so the notification must carry the old address. Directed sequences line up each of these collisions on purpose. A long random phase then mixes pulses, lock toggles, reads and compare-swaps, and about half of its compare operands are taken from the reference model's current owner so that swaps actually succeed. All of this is checked against a behavioural model on every clock.

// File: rtl/owner_notify_regs.sv
`timescale 1ns/1ps
module owner_notify_regs #(
  parameter int AW = 8,
  parameter int NSRC = 11,
  parameter logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_cmp,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [63:0]   rsp_rdata,
  input  logic          evt_rx_cfg,
  input  logic          evt_tx_cfg,
  input  logic          evt_lock,
  input  logic          evt_clk_acc,
  input  logic [NSRC-1:0] src_lock,
  input  logic [NSRC-1:0] src_slip,
  output logic          ntf_valid,
  output logic [15:0]   ntf_node,
  output logic [47:0]   ntf_offset,
  output logic [31:0]   ntf_data
);
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_CSWAP = 2'd2;
  localparam logic [AW-1:0] A_OWN_HI = AW'(8'h00);
  localparam logic [AW-1:0] A_OWN_LO = AW'(8'h04);
  localparam logic [AW-1:0] A_EVENT  = AW'(8'h08);
  localparam logic [AW-1:0] A_STATUS = AW'(8'h0C);

  logic [63:0]     owner_q;
  logic [6:0]      event_q;
  logic [NSRC-1:0] lock_q;
  logic [NSRC-1:0] slip_q;
  logic [63:0]     rd_mux;
  logic            rd_hit;

  wire is_read  = req_valid && req_op == OP_READ && req_addr[1:0] == 2'b00;
  wire cs_hit   = req_valid && req_op == OP_CSWAP && req_addr == A_OWN_HI;
  wire clr_slip = is_read && req_addr == A_STATUS;
  wire lock_chg = |(src_lock ^ lock_q);
  wire has_owner = owner_q != NO_OWNER;
  wire [6:0] evt_set = {lock_chg, evt_clk_acc, evt_lock, 2'b00, evt_tx_cfg, evt_rx_cfg};
  wire any_evt = |evt_set;
  wire [31:0] status_word = (32'(slip_q) << 16) | 32'(src_lock);

  always_comb begin
    rd_mux = 64'd0;
    rd_hit = 1'b0;
    if (cs_hit) begin
      rd_mux = owner_q;
      rd_hit = 1'b1;
    end else if (is_read) begin
      rd_hit = 1'b1;
      case (req_addr)
        A_OWN_HI: rd_mux = {32'd0, owner_q[63:32]};
        A_OWN_LO: rd_mux = {32'd0, owner_q[31:0]};
        A_EVENT:  rd_mux = {57'd0, event_q};
        A_STATUS: rd_mux = {32'd0, status_word};
        default:  rd_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= NO_OWNER;
      event_q    <= '0;
      lock_q     <= '0;
      slip_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_rdata  <= '0;
      ntf_valid  <= 1'b0;
      ntf_node   <= '0;
      ntf_offset <= '0;
      ntf_data   <= '0;
    end else begin
      lock_q <= src_lock;
      slip_q <= (clr_slip ? '0 : slip_q) | src_slip;
      if (bus_reset) owner_q <= NO_OWNER;
      else if (cs_hit && owner_q == req_cmp) owner_q <= req_wdata;
      if (any_evt) begin
        event_q    <= evt_set;
        ntf_node   <= owner_q[63:48];
        ntf_offset <= owner_q[47:0];
        ntf_data   <= {25'd0, evt_set};
      end
      ntf_valid <= any_evt && has_owner;
      rsp_valid <= req_valid;
      rsp_ok    <= rd_hit;
      rsp_rdata <= rd_mux;
    end
  end

  AST_BUS_RESET_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> owner_q == NO_OWNER); // R2
  AST_OWNER_ONLY_BY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset && !(req_valid && req_op == OP_CSWAP)) |=> $stable(owner_q)); // R3
  AST_NTF_DATA_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ntf_data[6:0] == event_q); // R4
  AST_NTF_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> {ntf_node, ntf_offset} != NO_OWNER); // R5
  AST_SLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_slip |=> (slip_q & $past(slip_q)) == $past(slip_q)); // R7
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_WRITE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) |=> (rsp_valid && !rsp_ok && rsp_rdata == 64'd0)); // R8
endmodule

// File: tb/owner_notify_regs_test.sv
`timescale 1ns/1ps
module owner_notify_regs_test;
  localparam int AW = 8;
  localparam int NSRC = 11;
  localparam logic [63:0] NOOWN = 64'hFFFF_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_cmp = '0, req_wdata = '0;
  logic evt_rx_cfg = 1'b0, evt_tx_cfg = 1'b0, evt_lock = 1'b0, evt_clk_acc = 1'b0;
  logic [NSRC-1:0] src_lock = '0, src_slip = '0;
  logic rsp_valid, rsp_ok, ntf_valid;
  logic [63:0] rsp_rdata;
  logic [15:0] ntf_node;
  logic [47:0] ntf_offset;
  logic [31:0] ntf_data;

  always #2.5 clk = ~clk;

  owner_notify_regs #(.AW(AW), .NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_cmp(req_cmp), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
    .evt_rx_cfg(evt_rx_cfg), .evt_tx_cfg(evt_tx_cfg), .evt_lock(evt_lock),
    .evt_clk_acc(evt_clk_acc), .src_lock(src_lock), .src_slip(src_slip),
    .ntf_valid(ntf_valid), .ntf_node(ntf_node), .ntf_offset(ntf_offset),
    .ntf_data(ntf_data));

  int compared = 0;
  int mismatched = 0;

  logic [63:0] m_owner = NOOWN;
  logic [31:0] m_event = 0;
  logic [NSRC-1:0] m_lock = 0, m_slip = 0;
  logic e_rv = 0, e_ok = 0, e_nv = 0;
  logic [63:0] e_rd = 0, e_naddr = 0;
  logic [31:0] e_nd = 0;

  task automatic model();
    logic [31:0] ev;
    if (!rst_n) begin
      m_owner = NOOWN; m_event = 0; m_lock = 0; m_slip = 0;
      e_rv = 0; e_ok = 0; e_rd = 0; e_nv = 0;
    end else begin
      e_rv = req_valid; e_ok = 0; e_rd = 0;
      if (req_valid && req_op == 2 && req_addr == 0) begin
        e_ok = 1; e_rd = m_owner;
      end else if (req_valid && req_op == 0) begin
        case (req_addr)
          8'h00: begin e_ok = 1; e_rd = {32'd0, m_owner[63:32]}; end
          8'h04: begin e_ok = 1; e_rd = {32'd0, m_owner[31:0]}; end
          8'h08: begin e_ok = 1; e_rd = {32'd0, m_event}; end
          8'h0C: begin e_ok = 1; e_rd = {32'd0, 5'd0, m_slip, 5'd0, src_lock}; end
          default: ;
        endcase
      end
      ev = 0;
      if (evt_rx_cfg) ev |= 32'h01;
      if (evt_tx_cfg) ev |= 32'h02;
      if (evt_lock) ev |= 32'h10;
      if (evt_clk_acc) ev |= 32'h20;
      if (src_lock != m_lock) ev |= 32'h40;
      e_nv = (ev != 0) && (m_owner != NOOWN);
      if (ev != 0) begin m_event = ev; e_nd = ev; e_naddr = m_owner; end
      if (req_valid && req_op == 0 && req_addr == 8'h0C) m_slip = 0;
      m_slip |= src_slip;
      m_lock = src_lock;
      if (bus_reset) m_owner = NOOWN;
      else if (req_valid && req_op == 2 && req_addr == 0 && req_cmp == m_owner) m_owner = req_wdata;
    end
  endtask

  task automatic check(string tag, bit c, logic [63:0] act, logic [63:0] exp, string what);
    compared++;
    if (!c) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    model();
    @(negedge clk);
    check(tag, rsp_valid === e_rv, 64'(rsp_valid), 64'(e_rv), "rsp_valid");
    if (e_rv) begin
      check(tag, rsp_ok === e_ok, 64'(rsp_ok), 64'(e_ok), "rsp_ok");
      check(tag, rsp_rdata === e_rd, rsp_rdata, e_rd, "rsp_rdata");
    end
    check(tag, ntf_valid === e_nv, 64'(ntf_valid), 64'(e_nv), "ntf_valid");
    if (e_nv) begin
      check(tag, {ntf_node, ntf_offset} === e_naddr, {ntf_node, ntf_offset}, e_naddr, "ntf_addr");
      check(tag, ntf_data === e_nd, 64'(ntf_data), 64'(e_nd), "ntf_data");
    end
    req_valid = 0; bus_reset = 0; src_slip = 0;
    evt_rx_cfg = 0; evt_tx_cfg = 0; evt_lock = 0; evt_clk_acc = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    req_valid = 1; req_op = 0; req_addr = a; step(tag);
  endtask

  task automatic cswap(logic [63:0] c, logic [63:0] w, string tag);
    req_valid = 1; req_op = 2; req_addr = 0; req_cmp = c; req_wdata = w; step(tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1");
    evt_rx_cfg = 1; step("R5"); step("R5");
    rd(8'h08, "R4");
    cswap(64'h1234, 64'h0001_0000_0000_4000, "R3");
    cswap(NOOWN, 64'hFFC2_0000_0000_1000, "R3");
    rd(8'h00, "R3"); rd(8'h04, "R3");
    evt_tx_cfg = 1; evt_clk_acc = 1; step("R4"); step("R5");
    rd(8'h08, "R4");
    evt_lock = 1; step("R4"); rd(8'h08, "R4");
    evt_rx_cfg = 1; cswap(64'hFFC2_0000_0000_1000, 64'h0003_0000_0000_2000, "R5");
    step("R5");
    src_lock = 11'h005; step("R6"); step("R6");
    rd(8'h0C, "R6"); rd(8'h08, "R6");
    src_slip = 11'h402; step("R7"); step("R7");
    rd(8'h0C, "R7"); src_slip = 11'h001; rd(8'h0C, "R7"); rd(8'h0C, "R7");
    req_valid = 1; req_op = 1; req_addr = 8'h08; req_wdata = 64'hFF; step("R8");
    rd(8'h02, "R8"); rd(8'h10, "R8");
    req_valid = 1; req_op = 2; req_addr = 8'h04; req_cmp = 0; req_wdata = 0; step("R8");
    req_valid = 1; req_op = 3; req_addr = 0; step("R8");
    rd(8'h08, "R8");
    bus_reset = 1; cswap(64'h0003_0000_0000_2000, 64'h0009_0000_0000_0000, "R2");
    rd(8'h00, "R2");
    evt_clk_acc = 1; step("R5"); step("R5");
    cswap(NOOWN, 64'h0011_0000_0000_0010, "R3");
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      evt_rx_cfg = ($urandom_range(0, 9) == 0);
      evt_tx_cfg = ($urandom_range(0, 9) == 0);
      evt_lock = ($urandom_range(0, 9) == 0);
      evt_clk_acc = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 15) == 0) src_lock = NSRC'($urandom);
      if ($urandom_range(0, 7) == 0) src_slip = NSRC'($urandom);
      bus_reset = ($urandom_range(0, 63) == 0);
      if (r < 40) begin
        req_valid = 1; req_op = 0; req_addr = 8'($urandom_range(0, 4) * 4);
      end else if (r < 60) begin
        req_valid = 1; req_op = 2; req_addr = 0;
        req_cmp = $urandom_range(0, 1) ? m_owner : {$urandom, $urandom};
        req_wdata = {$urandom, $urandom};
      end else if (r < 65) begin
        req_valid = 1; req_op = 2'($urandom); req_addr = 8'($urandom);
      end
      step("R4");
    end
    finish_run();
  end
endmodule